// File: doc/BRIEF.md
# Random Bitstream Health Monitor

This block watches the output of a random number source while it runs. It takes the serial stream one bit per valid cycle and the 32-bit words assembled from that stream, and it applies four online tests. The first counts ones in consecutive blocks of 20000 bits. The second and third flag runs of identical bits at two lengths, a shorter "long run" limit and a longer "noise" limit. The fourth flags an output word that repeats the word before it.

Each test produces a one-cycle event pulse. It also sets a sticky flag in an 8-bit status vector that a register block outside this one can read. A synchronous clear drops the flags and restarts every test from scratch.

Top module: `rng_health_mon`

## Requirements
- R1: The ones count is taken over consecutive blocks of 20000 valid bits. On the 20000th bit the monobit test fails when the block's ones count is 9654 or less, or 10346 or more. The count and the bit position then restart at zero for the next block.
- R2: A long-run event fires on the valid bit that makes 34 identical consecutive bits. It fires only once per run, however long the run grows.
- R3: A noise event fires on the valid bit that makes 48 identical consecutive bits. It also fires only once per run.
- R4: The run length restarts at 1 whenever the bit value differs from the previous valid bit. Cycles with bit_vld_i low have no effect on the run length or on the monobit block.
- R5: A stuck event fires when a word strobed by word_vld_i equals the previous strobed word. The first word after reset or after a clear is never compared.
- R6: Both fail_pulse_o and status_o use fixed bit positions: monobit on bit 7, long run on bit 5, noise on bit 3 and stuck on bit 2. All other bits are always 0.
- R7: A status bit stays set until clr_i is asserted. In a cycle with clr_i high, all flags are cleared and the block window, run length and previous-word history restart. Bit or word inputs in that same cycle are discarded.
- R8: An event pulse and its status bit are both visible in the cycle that follows the clock edge that sampled the triggering input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of flags and test state |
| bit_vld_i | input | 1 | Qualifies bit_i |
| bit_i | input | 1 | Serial random bit |
| word_vld_i | input | 1 | Qualifies word_i |
| word_i | input | 32 | Assembled output word |
| fail_pulse_o | output | 8 | One-cycle test failure events (bits 7, 5, 3, 2) |
| status_o | output | 8 | Sticky test failure flags (bits 7, 5, 3, 2) |

## Verification
The monobit test is driven with evenly spread patterns whose ones count sits exactly at 9654, 9655, 10345 and 10346. These show that both bounds are exclusive. A fully random block shows that a healthy stream passes. Directed runs of 33, 34, 48 and 60 identical bits, some with idle gaps inside them, separate the exact firing points and the once-per-run behaviour from a counter that refires or that counts idle cycles. A biased random stream then mixes long runs, a small alphabet of repeating words and occasional clears. It is checked cycle by cycle against a bench model, which exposes any error in the word history or in how clear takes priority.

// File: rtl/rng_health_pkg.sv
package rng_health_pkg;

  // Status and pulse vector layout
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned POS_MONO  = 7;
  localparam int unsigned POS_LONG  = 5;
  localparam int unsigned POS_NOISE = 3;
  localparam int unsigned POS_STUCK = 2;

  // True when a block's ones count lies outside the open pass band (lo, hi)
  function automatic logic ones_out_of_band(int unsigned n, int unsigned lo,
                                            int unsigned hi);
    return !((n > lo) && (n < hi));
  endfunction

  // Next run length: restart at 1 on a change, saturate at sat_max
  function automatic int unsigned run_step(int unsigned len, logic same,
                                           int unsigned sat_max);
    if (!same)          return 1;
    if (len >= sat_max) return sat_max;
    return len + 1;
  endfunction

endpackage

// File: rtl/rhm_monobit.sv
module rhm_monobit
  import rng_health_pkg::*;
#(
  parameter int unsigned WIN_BITS = 20000,
  parameter int unsigned ONES_LO  = 9654,
  parameter int unsigned ONES_HI  = 10346
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic fail_o
);
  localparam int unsigned CW = $clog2(WIN_BITS + 1);

  logic [CW-1:0] pos_q, ones_q;
  logic [CW-1:0] ones_next;
  logic          blk_end;
  logic          blk_bad;

  always_comb begin
    ones_next = ones_q + {{(CW-1){1'b0}}, bit_i};
    blk_end   = (pos_q == CW'(WIN_BITS - 1));
    blk_bad   = ones_out_of_band(int'(ones_next), ONES_LO, ONES_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      ones_q <= '0;
      fail_o <= 1'b0;
    end else if (clr_i) begin
      pos_q  <= '0;
      ones_q <= '0;
      fail_o <= 1'b0;
    end else begin
      fail_o <= 1'b0;
      if (bit_vld_i) begin
        if (blk_end) begin
          pos_q  <= '0;
          ones_q <= '0;
          fail_o <= blk_bad;
        end else begin
          pos_q  <= pos_q + 1'b1;
          ones_q <= ones_next;
        end
      end
    end
  end

  // R1: a monobit event only follows the closing bit of a block
  a_r1_fail_at_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (pos_q == '0 && ones_q == '0));

endmodule

// File: rtl/rhm_runlen.sv
module rhm_runlen
  import rng_health_pkg::*;
#(
  parameter int unsigned LONG_RUN  = 34,
  parameter int unsigned NOISE_RUN = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic long_o,
  output logic noise_o
);
  // Width leaves head-room above NOISE_RUN so saturation never re-hits a limit
  localparam int unsigned LW     = $clog2(NOISE_RUN + 2);
  localparam int unsigned SAT    = (1 << LW) - 1;
  localparam int unsigned NLIM   = 2;
  localparam int unsigned LIMS [NLIM] = '{LONG_RUN, NOISE_RUN};

  logic          have_q, last_q;
  logic [LW-1:0] len_q, len_next;
  logic          same_bit;
  logic [NLIM-1:0] hit;

  always_comb begin
    same_bit = have_q && (bit_i == last_q);
    len_next = LW'(run_step(int'(len_q), same_bit, SAT));
  end

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    assign hit[g] = bit_vld_i && (len_next == LW'(LIMS[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      last_q  <= 1'b0;
      len_q   <= '0;
      long_o  <= 1'b0;
      noise_o <= 1'b0;
    end else if (clr_i) begin
      have_q  <= 1'b0;
      last_q  <= 1'b0;
      len_q   <= '0;
      long_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      long_o  <= hit[0];
      noise_o <= hit[1];
      if (bit_vld_i) begin
        have_q <= 1'b1;
        last_q <= bit_i;
        len_q  <= len_next;
      end
    end
  end

  // R2: never two long-run events back to back
  a_r2_long_once: assert property (@(posedge clk) disable iff (!rst_n)
    long_o |=> !long_o);
  // R3: a noise event leaves the run length exactly at the noise limit
  a_r3_noise_len: assert property (@(posedge clk) disable iff (!rst_n)
    noise_o |-> (len_q == LW'(NOISE_RUN)));
  // R4: idle cycles leave the run length untouched
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !clr_i) |=> $stable(len_q));

endmodule

// File: rtl/rhm_stuck.sv
module rhm_stuck #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              stuck_o
);
  logic [WORD_W-1:0] prev_q;
  logic              have_q;
  logic              repeat_seen;

  assign repeat_seen = word_vld_i && have_q && (word_i == prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      stuck_o <= 1'b0;
    end else if (clr_i) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      stuck_o <= repeat_seen;
      if (word_vld_i) begin
        prev_q <= word_i;
        have_q <= 1'b1;
      end
    end
  end

  // R5: a stuck event needs a strobed word and an earlier word on record
  a_r5_stuck_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_o |-> ($past(word_vld_i) && have_q && !$past(clr_i)));

endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
  import rng_health_pkg::*;
#(
  parameter int unsigned WIN_BITS  = 20000,
  parameter int unsigned ONES_LO   = 9654,
  parameter int unsigned ONES_HI   = 10346,
  parameter int unsigned LONG_RUN  = 34,
  parameter int unsigned NOISE_RUN = 48,
  parameter int unsigned WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [7:0]        fail_pulse_o,
  output logic [7:0]        status_o
);
  logic mono_ev, long_ev, noise_ev, stuck_ev;
  logic [STAT_W-1:0] ev_vec;
  logic [STAT_W-1:0] hold_q;

  rhm_monobit #(.WIN_BITS(WIN_BITS), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI)) u_mono (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .fail_o(mono_ev));

  rhm_runlen #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .bit_vld_i(bit_vld_i), .bit_i(bit_i), .long_o(long_ev), .noise_o(noise_ev));

  rhm_stuck #(.WORD_W(WORD_W)) u_stuck (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .word_vld_i(word_vld_i), .word_i(word_i), .stuck_o(stuck_ev));

  always_comb begin
    ev_vec            = '0;
    ev_vec[POS_MONO]  = mono_ev;
    ev_vec[POS_LONG]  = long_ev;
    ev_vec[POS_NOISE] = noise_ev;
    ev_vec[POS_STUCK] = stuck_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (clr_i)  hold_q <= '0;
    else             hold_q <= hold_q | ev_vec;
  end

  assign fail_pulse_o = ev_vec;
  assign status_o     = hold_q | ev_vec;

  // R7: flags already set stay set while no clear arrives
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R7: a clear empties the status vector on the next cycle
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (status_o == '0));
  // R6: events only ever appear on the four assigned positions
  a_r6_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_pulse_o & 8'b0101_0011) == '0);

endmodule

// File: tb/rng_health_mon_tb_top.sv
`timescale 1ns/1ps
module rng_health_mon_tb_top;
  localparam int WIN = 20000;
  localparam int LO  = 9654;
  localparam int HI  = 10346;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        bit_vld_i = 1'b0;
  logic        bit_i = 1'b0;
  logic        word_vld_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [7:0]  fail_pulse_o, status_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // bench model
  int          m_pos = 0, m_ones = 0, m_run = 0;
  logic        m_have = 1'b0, m_last = 1'b0, m_hp = 1'b0;
  logic [31:0] m_prev = '0;
  logic [7:0]  m_ev = '0, m_stat = '0;

  always #5 clk = ~clk;

  rng_health_mon dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .word_vld_i(word_vld_i), .word_i(word_i),
    .fail_pulse_o(fail_pulse_o), .status_o(status_o));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic logic mono_bad(int ones);
    return (ones <= LO) || (ones >= HI);
  endfunction

  task automatic model(logic c, logic bv, logic b, logic wv, logic [31:0] w);
    m_ev = '0;
    if (c) begin
      m_pos = 0; m_ones = 0; m_run = 0; m_have = 0; m_last = 0;
      m_hp = 0; m_prev = '0; m_stat = '0;
      return;
    end
    if (bv) begin
      m_pos++; m_ones += int'(b);
      if (m_pos == WIN) begin
        m_ev[7] = mono_bad(m_ones);
        m_pos = 0; m_ones = 0;
      end
      if (!m_have || b != m_last) m_run = 1; else m_run++;
      m_ev[5] = (m_run == 34);
      m_ev[3] = (m_run == 48);
      m_have = 1; m_last = b;
    end
    if (wv) begin
      m_ev[2] = m_hp && (w == m_prev);
      m_prev = w; m_hp = 1;
    end
    m_stat = m_stat | m_ev;
  endtask

  task automatic step(logic c, logic bv, logic b, logic wv, logic [31:0] w);
    @(negedge clk);
    clr_i = c; bit_vld_i = bv; bit_i = b; word_vld_i = wv; word_i = w;
    @(posedge clk);
    #1;
    model(c, bv, b, wv, w);
    chk("R1 monobit pulse", {7'b0, fail_pulse_o[7]}, {7'b0, m_ev[7]});
    chk("R2 long-run pulse", {7'b0, fail_pulse_o[5]}, {7'b0, m_ev[5]});
    chk("R3 noise pulse", {7'b0, fail_pulse_o[3]}, {7'b0, m_ev[3]});
    chk("R5 stuck pulse", {7'b0, fail_pulse_o[2]}, {7'b0, m_ev[2]});
    chk("R6 unused bits", fail_pulse_o & 8'h53, 8'h00);
    chk("R7/R8 status", status_o, m_stat);
  endtask

  task automatic send_bit(logic b);
    step(1'b0, 1'b1, b, 1'b0, '0);
  endtask

  task automatic send_word(logic [31:0] w);
    step(1'b0, 1'b0, 1'b0, 1'b1, w);
  endtask

  task automatic do_clr();
    step(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  // R1: one block with exactly k ones, spread evenly
  task automatic mono_block(int k);
    do_clr();
    for (int i = 0; i < WIN; i++)
      send_bit(logic'(((i + 1) * k / WIN) - (i * k / WIN)));
    chk("R1 block verdict", {7'b0, status_o[7]}, {7'b0, mono_bad(k)});
  endtask

  task automatic run_of(logic b, int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset status", status_o, 8'h00);
    chk("R6 reset pulse", fail_pulse_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R1: random balanced block, then exact band edges
    do_clr();
    for (int i = 0; i < WIN; i++) send_bit(logic'($urandom & 1));
    mono_block(9654);
    mono_block(9655);
    mono_block(10345);
    mono_block(10346);

    // R2/R3: 33 equal bits do nothing, 60 equal bits fire each event once
    do_clr();
    send_bit(1'b1);
    run_of(1'b0, 33);
    chk("R2 no event at 33", status_o, 8'h00);
    send_bit(1'b1);
    run_of(1'b1, 59);
    chk("R3 both flags set", status_o & 8'h28, 8'h28);

    // R4: idle gaps inside a run are invisible
    do_clr();
    run_of(1'b0, 20);
    repeat (5) step(1'b0, 1'b0, 1'b1, 1'b0, '0);
    run_of(1'b0, 14);
    chk("R4 gap ignored, long fires", status_o[5] ? 8'h1 : 8'h0, 8'h1);
    run_of(1'b1, 10);

    // R5: repeated words and first word after clear
    do_clr();
    send_word(32'hA5A5_0001);
    send_word(32'h1234_5678);
    send_word(32'h1234_5678);
    send_word(32'h1234_5678);
    send_word(32'h0BAD_F00D);
    do_clr();
    send_word(32'h0BAD_F00D);
    chk("R5 first word after clear", status_o, 8'h00);

    // R7: clear in the same cycle as inputs discards them
    step(1'b1, 1'b1, 1'b1, 1'b1, 32'h0BAD_F00D);
    send_word(32'h0BAD_F00D);
    chk("R7 clear drops same-cycle word", status_o, 8'h00);

    // biased random mix
    for (int i = 0; i < 8000; i++) begin
      logic c, bv, b, wv;
      logic [31:0] w;
      c  = (($urandom % 700) == 0);
      bv = (($urandom % 4) != 0);
      b  = (($urandom % 16) == 0) ? ~m_last : m_last;
      wv = (($urandom % 4) == 0);
      w  = 32'h5000_0000 + ($urandom % 4);
      step(c, bv, b, wv, w);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 180000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

endmodule